// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small registered logic device. Twenty-two signals enter the array: twelve dedicated input pins (bit 0 of these is the pin that also carries the clock) and ten feedback lines from the I/O cells. Each signal reaches the array both as itself and as its inverse, which gives 44 columns. A connection map, loaded serially, selects which columns each of 132 product terms uses. Each product term is the AND of the columns it selects.

Groups of terms are ORed into ten output sums. The groups have unequal sizes: 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 terms for outputs 0 to 9. Each output also has one product term of its own that serves as its output enable. Two more terms are shared by all outputs: one feeds the asynchronous reset and one feeds the synchronous preset. The registers, polarity selection and pins that use these results sit outside the block.

Array evaluation is combinational. The only state is the connection map and a flag that records whether a complete map is in place. While no complete map is present, every array output is held at 0.

Top module: `pla_array`

## Requirements
- R1: Input k of the array is `ded_in[k]` for k < 12 and `fb_in[k-12]` for k >= 12. Column 2k carries input k and column 2k+1 carries its inverse.
- R2: A connection bit set to 1 includes its column in the product term, and the term is the AND of all included columns.
- R3: A product term with no connection bits set evaluates to 1.
- R4: A product term connected to both the true column and the inverse column of the same input evaluates to 0.
- R5: `sum_out[o]` is the OR of the sum rows of output o. Outputs 0 to 9 have 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 sum rows.
- R6: `oe_out[o]` is driven only by the single enable row that belongs to output o.
- R7: `reset_term` is row 0 and `preset_term` is row 131. Both are shared by all outputs.
- R8: Map layout and load order:
  - Row 0 is the reset row.
  - For each output o in ascending order there is its enable row, followed by its sum rows.
  - Row 131 is the preset row.
  - Connection (row r, column c) is stored at bit r*44+c of the map.
  - Each shift cycle moves every stored bit down by one place and places `cfg_data` at bit 5807. After 5808 shifts, the first bit shifted in sits at bit 0.
- R9: All outputs are 0 after reset. They are also 0 from the cycle after any cycle with `cfg_shift_en` high, until a load-done strobe is accepted.
- R10: A `cfg_done` pulse with `cfg_shift_en` low enables the outputs from the next clock edge. A `cfg_done` that coincides with `cfg_shift_en` high is ignored.
- R11: Once loaded, the outputs follow `ded_in` and `fb_in` in the same cycle, with no clock edge in between.
- R12: While `cfg_shift_en` is low, `cfg_data` has no effect on the stored map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map store and the loaded flag |
| rst_n | input | 1 | Synchronous active-low reset; clears the loaded flag |
| cfg_shift_en | input | 1 | Shift one map bit in on this edge |
| cfg_data | input | 1 | Serial map bit |
| cfg_done | input | 1 | Load-complete strobe |
| ded_in | input | 12 | Dedicated input pins; bit 0 is the clock-capable pin |
| fb_in | input | 10 | Feedback from the ten I/O cells |
| sum_out | output | 10 | OR sums, one per output |
| oe_out | output | 10 | Output-enable terms, one per output |
| reset_term | output | 1 | Shared asynchronous-reset term |
| preset_term | output | 1 | Shared synchronous-preset term |

## Verification
The bench connects a single input to the last row of each OR group and blocks every other row with a true/inverse pair. A design that gave a group the wrong size, or placed groups at the wrong offset, would miss that row or pick up a neighbour's row, and `sum_out` would show the wrong bit.

An empty map must drive every output to 1. A design that treated an empty term as 0 would show zeros there.

The bench also strobes done during the final shift and pulses one extra shift after a load. A design that accepted the early done, or kept driving outputs during a reload, would show nonzero outputs while they must read 0. A reversed shift direction would scramble the map that the reference model predicts.

Random maps with random inputs, together with toggling `cfg_data` while the shift enable is low, catch any column swap and any leak of idle serial data into the store.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
// pla_pkg: sizes and row layout shared by the array and its parts.
// Assumes the OR group sizes rise from the two ends toward the middle.
package pla_pkg;
    localparam int N_DED      = 12;
    localparam int N_FB       = 10;
    localparam int N_IN       = N_DED + N_FB;
    localparam int N_COL      = 2 * N_IN;
    localparam int N_OUT      = N_FB;
    localparam int BASE_TERMS = 8;
    localparam int STEP_TERMS = 2;

    // Number of sum rows for output o, growing with its distance from the nearer end.
    function automatic int sum_terms(input int o);
        int d;
        d = (o < N_OUT - 1 - o) ? o : N_OUT - 1 - o;
        return BASE_TERMS + STEP_TERMS * d;
    endfunction

    // Row index of the enable row of output o; its sum rows follow it directly.
    function automatic int oe_row(input int o);
        int r;
        r = 1;
        for (int j = 0; j < o; j++) r += sum_terms(j) + 1;
        return r;
    endfunction

    localparam int RESET_ROW  = 0;
    localparam int PRESET_ROW = oe_row(N_OUT);
    localparam int N_ROW      = PRESET_ROW + 1;
    localparam int N_FUSE     = N_ROW * N_COL;
endpackage

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
// pla_cfg_chain: serial store for the connection map and the loaded flag.
// Assumes the map needs no reset value; the outputs are gated until a load completes.
module pla_cfg_chain #(
    parameter int FUSE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              data,
    input  logic              done,
    output logic [FUSE_W-1:0] fuse,
    output logic              loaded
);
    // Shift the map one place toward bit 0, taking the new bit at the top.
    always_ff @(posedge clk) begin
        if (shift_en) fuse <= {data, fuse[FUSE_W-1:1]};
    end

    // Track whether a complete map is in place; a shift always wins over done.
    always_ff @(posedge clk) begin
        if (!rst_n)        loaded <= 1'b0;
        else if (shift_en) loaded <= 1'b0;
        else if (done)     loaded <= 1'b1;
    end

    assert_shift_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (fuse[FUSE_W-1] == $past(data)) &&
                     (fuse[FUSE_W-2:0] == $past(fuse[FUSE_W-1:1])));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(fuse));

    assert_done_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !shift_en) |=> loaded);

    assert_done_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !loaded);
endmodule

// File: rtl/pla_pterm.sv
`timescale 1ns/1ps
// pla_pterm: one product term, the AND of the columns whose connection bit is set.
// Assumes columns come in true/inverse pairs at positions 2k and 2k+1.
module pla_pterm #(
    parameter int W = 44
) (
    input  logic [W-1:0] cols,
    input  logic [W-1:0] conn,
    output logic         term
);
    logic [W/2-1:0] pair_hit;

    // Mark the inputs whose true and inverse columns are both connected.
    for (genvar k = 0; k < W / 2; k++) begin : g_pair
        assign pair_hit[k] = conn[2*k] & conn[2*k+1];
    end

    // A column that is not connected passes 1 into the AND.
    always_comb term = &(cols | ~conn);

    // Check that a connected true/inverse pair forces the term low.
    always_comb begin
        if (|pair_hit) assert_pair_kills_R4: assert (term == 1'b0);
    end
endmodule

// File: rtl/pla_or_group.sv
`timescale 1ns/1ps
// pla_or_group: N product terms ORed into one output sum.
// Assumes conns holds N rows of W bits, with row 0 in the low bits.
module pla_or_group #(
    parameter int N = 8,
    parameter int W = 44
) (
    input  logic [W-1:0]   cols,
    input  logic [N*W-1:0] conns,
    output logic           hit
);
    logic [N-1:0] terms;

    for (genvar t = 0; t < N; t++) begin : g_row
        pla_pterm #(.W(W)) u_row (
            .cols (cols),
            .conn (conns[t*W +: W]),
            .term (terms[t])
        );
    end

    // Combine the group's rows.
    always_comb hit = |terms;
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
// pla_array: programmable AND-OR core with ten unequal OR groups, one enable term
// per output, and shared reset and preset terms.
// Assumes the map is loaded serially before use; until then every output reads 0.
module pla_array (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_shift_en,
    input  logic                     cfg_data,
    input  logic                     cfg_done,
    input  logic [pla_pkg::N_DED-1:0] ded_in,
    input  logic [pla_pkg::N_FB-1:0]  fb_in,
    output logic [pla_pkg::N_OUT-1:0] sum_out,
    output logic [pla_pkg::N_OUT-1:0] oe_out,
    output logic                     reset_term,
    output logic                     preset_term
);
    import pla_pkg::*;

    logic [N_FUSE-1:0] fuse;
    logic              loaded;
    logic [N_IN-1:0]   in_vec;
    logic [N_COL-1:0]  cols;
    logic [N_OUT-1:0]  sum_raw, oe_raw;
    logic              reset_raw, preset_raw;

    pla_cfg_chain #(.FUSE_W(N_FUSE)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .data     (cfg_data),
        .done     (cfg_done),
        .fuse     (fuse),
        .loaded   (loaded)
    );

    // Gather the array inputs: dedicated pins low, feedback high.
    always_comb in_vec = {fb_in, ded_in};

    // Present each input in true and inverse form.
    for (genvar k = 0; k < N_IN; k++) begin : g_col
        assign cols[2*k]   = in_vec[k];
        assign cols[2*k+1] = ~in_vec[k];
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int ROW_OE = oe_row(o);
        localparam int N_SUM  = sum_terms(o);

        pla_pterm #(.W(N_COL)) u_oe (
            .cols (cols),
            .conn (fuse[ROW_OE*N_COL +: N_COL]),
            .term (oe_raw[o])
        );

        pla_or_group #(.N(N_SUM), .W(N_COL)) u_sum (
            .cols  (cols),
            .conns (fuse[(ROW_OE+1)*N_COL +: N_SUM*N_COL]),
            .hit   (sum_raw[o])
        );
    end

    pla_pterm #(.W(N_COL)) u_reset (
        .cols (cols),
        .conn (fuse[RESET_ROW*N_COL +: N_COL]),
        .term (reset_raw)
    );

    pla_pterm #(.W(N_COL)) u_preset (
        .cols (cols),
        .conn (fuse[PRESET_ROW*N_COL +: N_COL]),
        .term (preset_raw)
    );

    // Hold every output low until a complete map is in place.
    always_comb begin
        sum_out     = loaded ? sum_raw : '0;
        oe_out      = loaded ? oe_raw  : '0;
        reset_term  = loaded & reset_raw;
        preset_term = loaded & preset_raw;
    end

    assert_idle_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_shift_en) |-> (sum_out == '0 && oe_out == '0 && !reset_term && !preset_term));

    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(!rst_n) |-> (sum_out == '0 && oe_out == '0));
endmodule

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb;
    localparam int COLS = 44;
    localparam int ROWS = 132;
    localparam int TOT  = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shift_en = 1'b0, cfg_data = 1'b0, cfg_done = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_out;
    logic        reset_term, preset_term;

    logic [TOT-1:0] mdl;
    bit             mdl_loaded = 1'b0;
    int total = 0, bad = 0, cyc = 0;
    int sz [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

    always #5 clk = ~clk;

    pla_array u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_data(cfg_data),
        .cfg_done(cfg_done), .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out),
        .oe_out(oe_out), .reset_term(reset_term), .preset_term(preset_term)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad++; total++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int oe_row_of(int o);
        int r = 1;
        for (int j = 0; j < o; j++) r += sz[j] + 1;
        return r;
    endfunction

    function automatic bit row_val(int r);
        logic [21:0] iv;
        logic        c;
        iv = {fb_in, ded_in};
        for (int k = 0; k < COLS; k++) begin
            c = (k % 2 == 0) ? iv[k/2] : ~iv[k/2];
            if (mdl[r*COLS + k] && !c) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Expected {sum, oe, reset, preset} from the map and inputs.
    function automatic logic [21:0] expect_out();
        logic [9:0] s, e;
        if (!mdl_loaded) return '0;
        for (int o = 0; o < 10; o++) begin
            int b = oe_row_of(o);
            e[o] = row_val(b);
            s[o] = 1'b0;
            for (int t = 0; t < sz[o]; t++) s[o] |= row_val(b + 1 + t);
        end
        return {s, e, row_val(0), row_val(ROWS - 1)};
    endfunction

    task automatic check(string req, logic [21:0] exp);
        logic [21:0] act;
        act = {sum_out, oe_out, reset_term, preset_term};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_conn(int r, int c);
        mdl[r*COLS + c] = 1'b1;
    endtask

    // Shift the whole model map in, bit 0 first; optionally strobe done during the last shift.
    task automatic load_map(bit early_done);
        for (int i = 0; i < TOT; i++) begin
            @(negedge clk);
            cfg_shift_en = 1'b1; cfg_data = mdl[i];
            cfg_done = (early_done && i == TOT - 1);
        end
        @(negedge clk);
        cfg_shift_en = 1'b0; cfg_done = 1'b0;
        mdl_loaded = 1'b0;
        if (early_done) begin
            #1 check("R10 done during shift ignored", 22'h0);
        end
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        mdl_loaded = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset outputs", 22'h0);
    endtask

    task automatic t_empty_map();
        mdl = '0;
        load_map(1'b1);
        #1 check("R3 empty terms", {10'h3FF, 10'h3FF, 1'b1, 1'b1});
        ded_in = 12'hA5A; fb_in = 10'h2C3;
        #1 check("R3 empty terms other inputs", {10'h3FF, 10'h3FF, 1'b1, 1'b1});
    endtask

    task automatic t_directed();
        mdl = '0;
        for (int r = 0; r < ROWS; r++) begin
            set_conn(r, 0); set_conn(r, 1);
        end
        for (int o = 0; o < 10; o++) begin
            int b = oe_row_of(o);
            int last = b + sz[o];
            mdl[b*COLS +: COLS] = '0;
            set_conn(b, 2*(12+o)+1);
            mdl[last*COLS +: COLS] = '0;
            set_conn(last, 2*o);
        end
        mdl[0 +: COLS] = '0;
        set_conn(0, 20); set_conn(0, 22);
        mdl[(ROWS-1)*COLS +: COLS] = '0;
        set_conn(ROWS - 1, 21);
        load_map(1'b0);
        ded_in = '0; fb_in = '0;
        #1 check("R4 R6 R7 zero inputs", {10'h000, 10'h3FF, 1'b0, 1'b1});
        ded_in = 12'hC00;
        #1 check("R7 reset and preset terms", {10'h000, 10'h3FF, 1'b1, 1'b0});
        ded_in = '0; fb_in = 10'h3FF;
        #1 check("R6 enable terms off", {10'h000, 10'h000, 1'b0, 1'b1});
        fb_in = 10'h2A5;
        #1 check("R1 R6 feedback columns", {10'h000, ~10'h2A5, 1'b0, 1'b1});
        fb_in = '0;
        for (int o = 0; o < 10; o++) begin
            ded_in = 12'(1 << o);
            #1 check($sformatf("R5 R1 last row of group %0d", o), {10'(1 << o), 10'h3FF, 1'b0, 1'b1});
        end
    endtask

    task automatic t_random_map();
        mdl = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (r % 7 != 3) begin
                set_conn(r, $urandom % COLS);
                set_conn(r, $urandom % COLS);
            end
        end
        load_map(1'b0);
        // R11: inputs change with no clock edge before the sample.
        for (int i = 0; i < 30; i++) begin
            ded_in = 12'($urandom); fb_in = 10'($urandom);
            #1 check("R2 R5 R11 random map", expect_out());
        end
    endtask

    task automatic t_hold();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cfg_data = ~cfg_data;
        end
        cfg_data = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ded_in = 12'($urandom); fb_in = 10'($urandom);
            #1 check("R12 idle data ignored", expect_out());
        end
    endtask

    task automatic t_reshift();
        @(negedge clk);
        cfg_shift_en = 1'b1; cfg_data = 1'b1;
        @(negedge clk);
        cfg_shift_en = 1'b0; cfg_data = 1'b0;
        mdl = {1'b1, mdl[TOT-1:1]};
        mdl_loaded = 1'b0;
        #1 check("R9 outputs off after shift", 22'h0);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        mdl_loaded = 1'b1;
        for (int i = 0; i < 6; i++) begin
            ded_in = 12'($urandom); fb_in = 10'($urandom);
            #1 check("R8 R10 shifted map", expect_out());
        end
    endtask

    initial begin
        t_reset();
        t_empty_map();
        t_directed();
        t_random_map();
        t_hold();
        t_reshift();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule